// File: doc/BRIEF.md
# Passcode-Gated Cipher Mode Controller

This block sequences a small encrypt, unlock and reveal flow around an external 16-bit cipher core. In input mode a single data register tracks the switch bank. A mode-button pulse starts the core in encrypt direction on that register, and the returned ciphertext replaces the register contents. The controller then waits for a 4-bit passcode, keyed one bit per button pulse.

A wrong code sends the controller into a fixed-length lockout. During the lockout the display selector requests dashes and all buttons are ignored. After the lockout the controller is ready for a fresh attempt. A matching code starts the core in decrypt direction. The recovered text lands in the same data register and stays there until a further mode press returns the controller to input mode.

The button inputs are assumed to be clean single-cycle pulses. The cipher arithmetic and the seven-segment driving are outside the block: the display selector only tells the display logic what to show.

Top module: `pass_gate_ctrl`

## Requirements
- R1: After a synchronous reset, `data_q` is 0, `disp_sel` is 0 (show data), `core_start` and `core_decrypt` are 0, and the controller is in input mode.
- R2: In input mode, `data_q` takes the value of `sw_in` on every clock edge, so it shows the switches one cycle late.
- R3: A `btn_mode` pulse in input mode gives, in the next cycle, a single-cycle `core_start` with `core_decrypt` = 0 and `data_q` equal to the switches sampled with the press. `disp_sel` stays 0 while the core works.
- R4: A `core_done` pulse during encryption loads `core_result` into `data_q` and switches `disp_sel` to 1 (passcode prompt) in the next cycle.
- R5: In the prompt state, a `btn_one` pulse enters a 1 and a `btn_zero` pulse enters a 0. The first entered bit is the most significant. A cycle with both or neither pulse enters nothing. Nothing is compared until the fourth bit is entered.
- R6: A fourth bit that completes a code different from `PASSCODE` (default 4'b1011) sets `disp_sel` to 2 (dashes) for exactly `LOCK_CYCLES` cycles. The selector then returns to 1, with an empty code.
- R7: Passcode buttons are ignored outside the prompt state, which covers cipher busy time and lockout. `btn_mode` is ignored except in input mode and in the result state.
- R8: A fourth bit that completes a code equal to `PASSCODE` gives, in the next cycle, a single-cycle `core_start` with `core_decrypt` = 1 and `disp_sel` = 0.
- R9: A `core_done` pulse during decryption loads `core_result` into `data_q`. The value then holds regardless of the switches. A further `btn_mode` pulse returns to input mode without a `core_start`, and the switches are loaded one cycle after that.
- R10: `data_q` does not change while the controller is prompting or locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | 16 | Switch bank holding the message |
| btn_mode | input | 1 | Mode button pulse |
| btn_zero | input | 1 | Passcode button pulse entering a 0 |
| btn_one | input | 1 | Passcode button pulse entering a 1 |
| core_done | input | 1 | Cipher core completion pulse |
| core_result | input | 16 | Cipher core output, valid with core_done |
| core_start | output | 1 | Single-cycle start pulse to the cipher core |
| core_decrypt | output | 1 | Cipher direction: 0 encrypt, 1 decrypt |
| data_q | output | 16 | Data register: plaintext, ciphertext or recovered text; also the core operand |
| disp_sel | output | 2 | Display request: 0 data, 1 prompt, 2 dashes |

## Verification
A corrupt state register shows at once on `disp_sel`, because each state maps to one selector value. It also shows as a missing or extra `core_start` on the next button press. A code collector that miscounts compares early or late, so after the third or fourth bit the selector moves one press away from the expected point. A lockout counter off by one changes by a single cycle the time the dashes are shown, so the sweep times every wrong code of the exhaustive set to the exact cycle. A load enable that is wrong shows as `data_q` moving while prompting, or not following the switches one cycle after an edge.

// File: rtl/pass_gate_pkg.sv
package pass_gate_pkg;

  typedef enum logic [2:0] {
    ST_INPUT = 3'd0,
    ST_ENC   = 3'd1,
    ST_CHECK = 3'd2,
    ST_LOCK  = 3'd3,
    ST_DEC   = 3'd4,
    ST_SHOW  = 3'd5
  } gate_st_t;

  typedef enum logic [1:0] {
    DISP_DATA   = 2'd0,
    DISP_PROMPT = 2'd1,
    DISP_DASH   = 2'd2
  } disp_t;

  function automatic disp_t disp_of(input gate_st_t st);
    case (st)
      ST_CHECK: disp_of = DISP_PROMPT;
      ST_LOCK:  disp_of = DISP_DASH;
      default:  disp_of = DISP_DATA;
    endcase
  endfunction

endpackage

// File: rtl/code_collector.sv
module code_collector #(
  parameter int          CODE_W   = 4,
  parameter logic [CODE_W-1:0] PASSCODE = 4'b1011
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bit_zero,
  input  logic bit_one,
  output logic full,
  output logic match
);
  localparam int CNT_W = (CODE_W > 2) ? $clog2(CODE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              press;
  logic [CODE_W-1:0] assembled;

  assign press     = enable && (bit_zero ^ bit_one);
  assign assembled = {code_q[CODE_W-2:0], bit_one};
  assign full      = press && (cnt_q == LAST);
  assign match     = full && (assembled == PASSCODE);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (press) begin
      cnt_q  <= full ? '0 : cnt_q + 1'b1;
      code_q <= assembled;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !press) |=> (cnt_q == $past(cnt_q)) || (cnt_q == '0));

  // R5
  wrap_after_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |=> (cnt_q == '0));

endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int LOCK_CYCLES = 200_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic run,
  output logic expired
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LW-1:0] RELOAD = LW'(LOCK_CYCLES - 1);

  logic [LW-1:0] cnt_q;

  assign expired = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (arm)
      cnt_q <= RELOAD;
    else if (run && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // R6
  countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !arm && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  arm_load_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (cnt_q == RELOAD));

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
  import pass_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     btn_mode,
  input  logic     code_full,
  input  logic     code_match,
  input  logic     core_done,
  input  logic     lock_expired,
  output gate_st_t st_q,
  output logic     start_q,
  output logic     decrypt_q,
  output logic [1:0] disp_q,
  output logic     collect_en,
  output logic     lock_arm,
  output logic     lock_run,
  output logic     load_sw,
  output logic     load_result
);
  gate_st_t st_n;
  logic     start_n;
  logic     decrypt_n;

  always_comb begin
    st_n      = st_q;
    start_n   = 1'b0;
    decrypt_n = decrypt_q;
    case (st_q)
      ST_INPUT: if (btn_mode) begin
        st_n = ST_ENC; start_n = 1'b1; decrypt_n = 1'b0;
      end
      ST_ENC:   if (core_done) st_n = ST_CHECK;
      ST_CHECK: if (code_full) begin
        if (code_match) begin
          st_n = ST_DEC; start_n = 1'b1; decrypt_n = 1'b1;
        end else begin
          st_n = ST_LOCK;
        end
      end
      ST_LOCK:  if (lock_expired) st_n = ST_CHECK;
      ST_DEC:   if (core_done) st_n = ST_SHOW;
      ST_SHOW:  if (btn_mode) st_n = ST_INPUT;
      default:  st_n = ST_INPUT;
    endcase
  end

  assign collect_en  = (st_q == ST_CHECK);
  assign lock_arm    = (st_q == ST_CHECK) && code_full && !code_match;
  assign lock_run    = (st_q == ST_LOCK);
  assign load_sw     = (st_q == ST_INPUT);
  assign load_result = ((st_q == ST_ENC) || (st_q == ST_DEC)) && core_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_INPUT;
      start_q   <= 1'b0;
      decrypt_q <= 1'b0;
      disp_q    <= DISP_DATA;
    end else begin
      st_q      <= st_n;
      start_q   <= start_n;
      decrypt_q <= decrypt_n;
      disp_q    <= disp_of(st_n);
    end
  end

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  // R8
  dec_after_check_chk: assert property (@(posedge clk) disable iff (rst)
    (start_q && decrypt_q) |-> ($past(st_q) == ST_CHECK));

  // R6
  dash_only_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_q == DISP_DASH) |-> (st_q == ST_LOCK));

endmodule

// File: rtl/pass_gate_ctrl.sv
module pass_gate_ctrl
  import pass_gate_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CODE_W      = 4,
  parameter logic [CODE_W-1:0] PASSCODE = 4'b1011,
  parameter int LOCK_CYCLES = 200_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sw_in,
  input  logic              btn_mode,
  input  logic              btn_zero,
  input  logic              btn_one,
  input  logic              core_done,
  input  logic [DATA_W-1:0] core_result,
  output logic              core_start,
  output logic              core_decrypt,
  output logic [DATA_W-1:0] data_q,
  output logic [1:0]        disp_sel
);
  gate_st_t st;
  logic     code_full, code_match, collect_en;
  logic     lock_arm, lock_run, lock_expired;
  logic     load_sw, load_result;

  gate_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .btn_mode    (btn_mode),
    .code_full   (code_full),
    .code_match  (code_match),
    .core_done   (core_done),
    .lock_expired(lock_expired),
    .st_q        (st),
    .start_q     (core_start),
    .decrypt_q   (core_decrypt),
    .disp_q      (disp_sel),
    .collect_en  (collect_en),
    .lock_arm    (lock_arm),
    .lock_run    (lock_run),
    .load_sw     (load_sw),
    .load_result (load_result)
  );

  code_collector #(.CODE_W(CODE_W), .PASSCODE(PASSCODE)) u_code (
    .clk     (clk),
    .rst     (rst),
    .enable  (collect_en),
    .bit_zero(btn_zero),
    .bit_one (btn_one),
    .full    (code_full),
    .match   (code_match)
  );

  lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .arm    (lock_arm),
    .run    (lock_run),
    .expired(lock_expired)
  );

  always_ff @(posedge clk) begin
    if (rst)
      data_q <= '0;
    else if (load_result)
      data_q <= core_result;
    else if (load_sw)
      data_q <= sw_in;
  end

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_CHECK) || (st == ST_LOCK)) |=> $stable(data_q));

  // R2
  switch_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_INPUT) |=> (data_q == $past(sw_in)));

endmodule

// File: tb/sim_pass_gate_ctrl.sv
module sim_pass_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 12;
  localparam logic [3:0] PASS = 4'b1011;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] sw_in = '0;
  logic btn_mode = 1'b0, btn_zero = 1'b0, btn_one = 1'b0;
  logic core_done = 1'b0;
  logic [15:0] core_result = '0;
  logic core_start, core_decrypt;
  logic [15:0] data_q;
  logic [1:0] disp_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pass_gate_ctrl #(.LOCK_CYCLES(LOCK), .PASSCODE(PASS)) u0 (
    .clk(clk), .rst(rst), .sw_in(sw_in), .btn_mode(btn_mode),
    .btn_zero(btn_zero), .btn_one(btn_one), .core_done(core_done),
    .core_result(core_result), .core_start(core_start),
    .core_decrypt(core_decrypt), .data_q(data_q), .disp_sel(disp_sel)
  );

  function automatic logic [15:0] enc(input logic [15:0] x);
    return {x[12:0], x[15:13]} ^ KEY;
  endfunction
  function automatic logic [15:0] dec(input logic [15:0] y);
    logic [15:0] z;
    z = y ^ KEY;
    return {z[2:0], z[15:3]};
  endfunction

  // cipher core model, three cycles of latency
  logic [15:0] op;
  logic        op_dec;
  logic        pend = 1'b0;
  int          lat = 0;
  always @(negedge clk) begin
    core_done = 1'b0;
    if (core_start) begin
      pend = 1'b1; lat = 3; op = data_q; op_dec = core_decrypt;
    end else if (pend) begin
      lat = lat - 1;
      if (lat == 0) begin
        core_done = 1'b1;
        core_result = op_dec ? dec(op) : enc(op);
        pend = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic press_bit(input logic b);
    btn_one = b; btn_zero = ~b;
    tick();
    btn_one = 1'b0; btn_zero = 1'b0;
  endtask

  task automatic wait_prompt();
    for (int i = 0; i < 12 && disp_sel != 2'd1; i++) tick();
  endtask

  task automatic run_message(input logic [15:0] m, input int first_code);
    int c;
    sw_in = m; tick(); tick();
    chk(data_q == m, "R2 switch load", data_q, m);
    chk(disp_sel == 2'd0, "R2 data display", disp_sel, 0);
    btn_mode = 1'b1; tick(); btn_mode = 1'b0;
    chk(core_start && !core_decrypt, "R3 encrypt start", {core_start, core_decrypt}, 2'b10);
    chk(data_q == m, "R3 operand", data_q, m);
    press_bit(1'b1); // R7 ignored while busy
    chk(!core_start && disp_sel == 2'd0, "R3 single start", {core_start, disp_sel}, 0);
    wait_prompt();
    chk(disp_sel == 2'd1, "R4 prompt", disp_sel, 1);
    chk(data_q == enc(m), "R4 ciphertext", data_q, enc(m));
    btn_mode = 1'b1; tick(); btn_mode = 1'b0;
    chk(!core_start && disp_sel == 2'd1, "R7 mode ignored in prompt", {core_start, disp_sel}, 1);
    btn_one = 1'b1; btn_zero = 1'b1; tick(); btn_one = 1'b0; btn_zero = 1'b0;
    chk(disp_sel == 2'd1, "R5 double press ignored", disp_sel, 1);
    c = first_code;
    forever begin
      for (int b = 3; b >= 1; b--) press_bit(c[b]);
      chk(disp_sel == 2'd1 && !core_start, "R5 no compare before fourth", disp_sel, 1);
      press_bit(c[0]);
      if (c[3:0] == PASS) begin
        chk(core_start && core_decrypt, "R8 decrypt start", {core_start, core_decrypt}, 2'b11);
        chk(disp_sel == 2'd0, "R8 data display", disp_sel, 0);
        break;
      end
      chk(disp_sel == 2'd2, "R6 dashes", disp_sel, 2);
      btn_one = 1'b1; // R7 presses during lockout
      for (int i = 1; i < LOCK; i++) begin
        tick();
        chk(disp_sel == 2'd2, "R6 lockout length", disp_sel, 2);
        chk(data_q == enc(m), "R10 hold in lockout", data_q, enc(m));
      end
      btn_one = 1'b0;
      tick();
      chk(disp_sel == 2'd1, "R6 back to prompt", disp_sel, 1);
      c = (c + 1) % 16;
    end
    for (int i = 0; i < 12 && data_q != m; i++) tick();
    chk(data_q == m, "R9 recovered text", data_q, m);
    sw_in = ~m; tick(); tick();
    chk(data_q == m, "R9 result holds", data_q, m);
    btn_mode = 1'b1; tick(); btn_mode = 1'b0;
    chk(!core_start, "R9 no start on return", core_start, 0);
    tick();
    chk(data_q == ~m, "R9 input mode again", data_q, ~m);
  endtask

  initial begin
    tick(); tick();
    rst = 1'b0;
    tick();
    chk(data_q == 16'h0 && disp_sel == 2'd0, "R1 reset outputs", {data_q, disp_sel}, 0);
    chk(!core_start && !core_decrypt, "R1 reset core", {core_start, core_decrypt}, 0);
    run_message(16'h1234, 12);
    run_message(16'hFFFF, 0);
    run_message(16'h0000, 5);
    run_message(16'hBEEF, 11);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule